// File: doc/BRIEF.md
# Two-Dimensional Descriptor Address Generator

This block turns one 128-bit transfer descriptor into the ordered list of word addresses that a DMA engine must visit to move a block. The descriptor holds four 32-bit words: a start index (word 0, bits 31:0), an X word (word 1), a Y word (word 2) and a control word (word 3, bits 127:96). The generator walks a single run of operands, or a grid of rows when two-dimensional mode is set. Each issued operand carries a length code: one, two or four 32-bit words. Counts and modifies are always in 32-bit word units, whatever the operand size.

Software, or another engine, writes a descriptor into an idle generator. A legal descriptor starts the walk at once. Operands are either streamed one per cycle or released one per external request. When the last operand has been issued, the generator can pulse an interrupt. It can also fetch the next descriptor from memory through a simple read port and restart without help. A write that arrives while a walk or a fetch is in progress is thrown away and flagged.

Top module: `dma2d_agen`

## Requirements
- R1: After reset the generator is idle. `busy`, `xfer_valid`, `mem_rd_en`, `done_irq` and `desc_err` are all low.
- R2: A `desc_wr` pulse on an idle generator loads `desc_in`. The walk starts only when the device type (control bits 31:29) is non-zero and the length code (control bits 26:25) is not 00. Otherwise the generator stays idle and issues nothing.
- R3: One-dimensional walk. The first operand goes to the index word. Each later operand goes to the previous address plus the X modify (X word bits 15:0, sign-extended). Each operand takes its size in words (code 01 = 1, 10 = 2, 11 = 4) off the X count (X word bits 31:16). The operand issued while the remaining count is at most its size is the last one.
- R4: In one-dimensional mode (control bit 27 clear) the Y word has no effect. In two-dimensional mode a row ends as in R3. Then, if more than one row remains (Y word bits 31:16), the next address is the last address plus the Y modify (Y word bits 15:0, sign-extended), the X count reloads and the row count drops by one. The last operand of the last row ends the block.
- R5: With control bit 23 set, an operand is presented only in a cycle in which `xfer_req` is high. It appears in that same cycle, and the walk holds while `xfer_req` is low. With bit 23 clear, one operand is presented every cycle.
- R6: With control bit 24 set, `done_irq` is high for exactly one cycle: the cycle after the block's last operand. With bit 24 clear it stays low.
- R7: A `desc_wr` pulse while `busy` is high does not change the walk in progress. It makes `desc_err` high for exactly the next cycle.
- R8: With control bit 22 set, after the last operand the generator reads four words, one per cycle, in index order. The read address is {bits 16:15, bits 14:0, word number}. Data arrives on `mem_rd_data` the cycle after each read. The four words are then loaded as a new descriptor under the rules of R2.
- R9: When chaining is set but the memory block field (bits 16:15) is 11, no read is made and the generator returns to idle after the last operand.
- R10: `xfer_len` equals the length code of the running descriptor whenever `xfer_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_in | input | 128 | Descriptor: word 0 index, word 1 X, word 2 Y, word 3 control |
| xfer_req | input | 1 | External request, used in request mode |
| xfer_valid | output | 1 | An operand is issued this cycle |
| xfer_addr | output | AW (32) | Word address of the operand |
| xfer_len | output | 2 | Operand length code |
| busy | output | 1 | A walk or a descriptor fetch is in progress |
| done_irq | output | 1 | One-cycle end-of-block pulse |
| desc_err | output | 1 | One-cycle pulse for a rejected descriptor write |
| mem_rd_en | output | 1 | Descriptor fetch read strobe |
| mem_rd_addr | output | 19 | Fetch word address: block, pointer, word number |
| mem_rd_data | input | 32 | Fetch data, valid the cycle after the read |

## Verification
The first operand of a loaded descriptor is due in the cycle after the loading edge. In request mode an operand appears in the same cycle as its request, so the bench drives `xfer_req` on a falling edge and samples shortly after it. `done_irq` and `desc_err` are each due one cycle after their cause. In a chained reload the four reads fill consecutive cycles, and the first new operand comes two cycles after the last read. Every output is sampled on the falling clock edge, so each comparison lands in exactly the cycle worked out from these latencies.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 16;
    localparam int PTR_W   = 15;
    localparam int FADDR_W = 2 + PTR_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FETCH = 2'd2
    } agen_st_e;

    typedef struct packed {
        logic [2:0]       dev_type;
        logic             two_d;
        logic [1:0]       len;
        logic             irq_en;
        logic             req_mode;
        logic             chain_en;
        logic [1:0]       chain_blk;
        logic [PTR_W-1:0] chain_ptr;
    } ctrl_t;
endpackage

// File: rtl/dma2d_ctrl_dec.sv
module dma2d_ctrl_dec
    import dma2d_pkg::*;
(
    input  logic [WORD_W-1:0] ctrl_word,
    output ctrl_t             ctrl,
    output logic [2:0]        step_words,
    output logic              start_ok
);
    always_comb begin
        ctrl.dev_type  = ctrl_word[31:29];
        ctrl.two_d     = ctrl_word[27];
        ctrl.len       = ctrl_word[26:25];
        ctrl.irq_en    = ctrl_word[24];
        ctrl.req_mode  = ctrl_word[23];
        ctrl.chain_en  = ctrl_word[22];
        ctrl.chain_blk = ctrl_word[16:15];
        ctrl.chain_ptr = ctrl_word[14:0];
        case (ctrl_word[26:25])
            2'b01:   step_words = 3'd1;
            2'b10:   step_words = 3'd2;
            2'b11:   step_words = 3'd4;
            default: step_words = 3'd0;
        endcase
        start_ok = (ctrl_word[31:29] != 3'b000) && (ctrl_word[26:25] != 2'b00);
    end
endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] xcnt,
    input  logic [CW-1:0] ycnt,
    input  logic [CW-1:0] xinit,
    input  logic [CW-1:0] xmod,
    input  logic [CW-1:0] ymod,
    input  logic [2:0]    step_words,
    input  logic          two_d,
    output logic [AW-1:0] nxt_addr,
    output logic [CW-1:0] nxt_xcnt,
    output logic [CW-1:0] nxt_ycnt,
    output logic          last_op
);
    localparam int PAD = AW - CW;
    localparam logic [CW-1:0] ONE_ROW = CW'(1);

    logic [CW-1:0] step_ext;
    logic [AW-1:0] xmod_ext;
    logic [AW-1:0] ymod_ext;
    logic          row_end;
    logic          more_rows;

    assign step_ext = {{(CW-3){1'b0}}, step_words};
    assign xmod_ext = {{PAD{xmod[CW-1]}}, xmod};
    assign ymod_ext = {{PAD{ymod[CW-1]}}, ymod};

    always_comb begin
        row_end   = (xcnt <= step_ext);
        more_rows = two_d && (ycnt > ONE_ROW);
        nxt_addr  = cur_addr + xmod_ext;
        nxt_xcnt  = xcnt - step_ext;
        nxt_ycnt  = ycnt;
        last_op   = 1'b0;
        if (row_end) begin
            if (more_rows) begin
                nxt_addr = cur_addr + ymod_ext;
                nxt_xcnt = xinit;
                nxt_ycnt = ycnt - ONE_ROW;
            end else begin
                last_op = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
    import dma2d_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 desc_wr,
    input  logic [4*WORD_W-1:0]  desc_in,
    input  logic                 xfer_req,
    output logic                 xfer_valid,
    output logic [AW-1:0]        xfer_addr,
    output logic [1:0]           xfer_len,
    output logic                 busy,
    output logic                 done_irq,
    output logic                 desc_err,
    output logic                 mem_rd_en,
    output logic [FADDR_W-1:0]   mem_rd_addr,
    input  logic [WORD_W-1:0]    mem_rd_data
);
    localparam int DESC_W = 4 * WORD_W;
    localparam logic [2:0] FETCH_LAST = 3'd4;

    typedef struct packed {
        agen_st_e                     st;
        logic [AW-1:0]                addr;
        logic [CNT_W-1:0]             xcnt;
        logic [CNT_W-1:0]             ycnt;
        logic [CNT_W-1:0]             xinit;
        logic [CNT_W-1:0]             xmod;
        logic [CNT_W-1:0]             ymod;
        ctrl_t                        ctrl;
        logic [2:0]                   step;
        logic [2:0]                   fcnt;
        logic [2:0][WORD_W-1:0]       fbuf;
        logic                         irq;
        logic                         err;
    } regs_t;

    regs_t q, d;

    logic [DESC_W-1:0] ld_w;
    ctrl_t             ld_ctrl;
    logic [2:0]        ld_step;
    logic              ld_ok;
    logic              issue;
    logic [AW-1:0]     s_addr;
    logic [CNT_W-1:0]  s_xcnt;
    logic [CNT_W-1:0]  s_ycnt;
    logic              s_last;

    assign ld_w = (q.st == ST_FETCH)
                ? {mem_rd_data, q.fbuf[2], q.fbuf[1], q.fbuf[0]}
                : desc_in;

    dma2d_ctrl_dec u_dec (
        .ctrl_word  (ld_w[DESC_W-1 -: WORD_W]),
        .ctrl       (ld_ctrl),
        .step_words (ld_step),
        .start_ok   (ld_ok)
    );

    dma2d_addr_step #(.AW(AW), .CW(CNT_W)) u_step (
        .cur_addr   (q.addr),
        .xcnt       (q.xcnt),
        .ycnt       (q.ycnt),
        .xinit      (q.xinit),
        .xmod       (q.xmod),
        .ymod       (q.ymod),
        .step_words (q.step),
        .two_d      (q.ctrl.two_d),
        .nxt_addr   (s_addr),
        .nxt_xcnt   (s_xcnt),
        .nxt_ycnt   (s_ycnt),
        .last_op    (s_last)
    );

    assign issue = (q.st == ST_RUN) && (!q.ctrl.req_mode || xfer_req);

    always_comb begin
        logic load;
        d     = q;
        d.irq = 1'b0;
        d.err = 1'b0;
        load  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                load = desc_wr;
            end
            ST_RUN: begin
                d.err = desc_wr;
                if (issue) begin
                    if (s_last) begin
                        d.irq = q.ctrl.irq_en;
                        if (q.ctrl.chain_en && (q.ctrl.chain_blk != 2'b11)) begin
                            d.st   = ST_FETCH;
                            d.fcnt = 3'd0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.addr = s_addr;
                        d.xcnt = s_xcnt;
                        d.ycnt = s_ycnt;
                    end
                end
            end
            ST_FETCH: begin
                d.err  = desc_wr;
                d.fcnt = q.fcnt + 3'd1;
                if ((q.fcnt != 3'd0) && (q.fcnt < FETCH_LAST)) begin
                    d.fbuf[q.fcnt - 3'd1] = mem_rd_data;
                end
                load = (q.fcnt == FETCH_LAST);
            end
            default: d.st = ST_IDLE;
        endcase
        if (load) begin
            d.addr  = ld_w[AW-1:0];
            d.xmod  = ld_w[WORD_W +: CNT_W];
            d.xcnt  = ld_w[WORD_W+CNT_W +: CNT_W];
            d.xinit = ld_w[WORD_W+CNT_W +: CNT_W];
            d.ymod  = ld_w[2*WORD_W +: CNT_W];
            d.ycnt  = ld_w[2*WORD_W+CNT_W +: CNT_W];
            d.ctrl  = ld_ctrl;
            d.step  = ld_step;
            d.st    = ld_ok ? ST_RUN : ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign xfer_valid  = issue;
    assign xfer_addr   = q.addr;
    assign xfer_len    = q.ctrl.len;
    assign busy        = (q.st != ST_IDLE);
    assign done_irq    = q.irq;
    assign desc_err    = q.err;
    assign mem_rd_en   = (q.st == ST_FETCH) && (q.fcnt < FETCH_LAST);
    assign mem_rd_addr = {q.ctrl.chain_blk, q.ctrl.chain_ptr, q.fcnt[1:0]};
endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        desc_wr,
    input logic        busy,
    input logic        desc_err,
    input logic        xfer_valid,
    input logic [1:0]  xfer_len,
    input logic        done_irq,
    input logic        mem_rd_en,
    input logic [18:0] mem_rd_addr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!xfer_valid && !mem_rd_en)); // R1

    AST_LIVE_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && busy) |=> desc_err); // R7

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |-> $past(desc_wr && busy)); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R6

    AST_IRQ_AFTER_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(xfer_valid)); // R6

    AST_FETCH_NO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !xfer_valid); // R8

    AST_FETCH_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == 19'($past(mem_rd_addr) + 19'd1))); // R8

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_len != 2'b00)); // R10
endmodule

bind dma2d_agen dma2d_agen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_wr     (desc_wr),
    .busy        (busy),
    .desc_err    (desc_err),
    .xfer_valid  (xfer_valid),
    .xfer_len    (xfer_len),
    .done_irq    (done_irq),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/dma2d_agen_tb.sv
module dma2d_agen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // each entry: ctrl, Y, X, index, expected count, first addr, last addr, address sum
    localparam logic [255:0] VECS [NVEC] = '{
        {32'h4600_0000, 32'h0000_0000, 32'h0010_0004, 32'h0000_0100, 32'd4,  32'h100,  32'h10C,  32'd1048},
        {32'h8200_0000, 32'h0000_0000, 32'h0003_FFFF, 32'h0000_0020, 32'd3,  32'h20,   32'h1E,   32'd93},
        {32'h4E00_0000, 32'h0008_0004, 32'h0008_0004, 32'h0000_0000, 32'd16, 32'h0,    32'd60,   32'd480},
        {32'h4C00_0000, 32'h0003_0010, 32'h0004_0002, 32'h0000_1000, 32'd6,  32'h1000, 32'h1026, 32'd24690},
        {32'h4600_0000, 32'hDEAD_BEEF, 32'h0010_0004, 32'h0000_0100, 32'd4,  32'h100,  32'h10C,  32'd1048},
        {32'h0600_0000, 32'h0000_0000, 32'h0010_0004, 32'h0000_0100, 32'd0,  32'h0,    32'h0,    32'd0},
        {32'h4000_0000, 32'h0000_0000, 32'h0010_0004, 32'h0000_0100, 32'd0,  32'h0,    32'h0,    32'd0},
        {32'h4400_0000, 32'h0000_0000, 32'h0005_0002, 32'h0000_0040, 32'd3,  32'h40,   32'h44,   32'd198}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         desc_wr;
    logic [127:0] desc_in;
    logic         xfer_req;
    logic         xfer_valid;
    logic [31:0]  xfer_addr;
    logic [1:0]   xfer_len;
    logic         busy;
    logic         done_irq;
    logic         desc_err;
    logic         mem_rd_en;
    logic [18:0]  mem_rd_addr;
    logic [31:0]  mem_rd_data;

    int checks = 0;
    int fails  = 0;

    logic [255:0] cur;
    int           n_op;
    int           n_rd;
    logic [31:0]  op_first, op_last, op_sum;
    logic         len_ok;
    logic [31:0]  op_log [8];
    logic [18:0]  rd_log [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2d_agen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .desc_wr     (desc_wr),
        .desc_in     (desc_in),
        .xfer_req    (xfer_req),
        .xfer_valid  (xfer_valid),
        .xfer_addr   (xfer_addr),
        .xfer_len    (xfer_len),
        .busy        (busy),
        .done_irq    (done_irq),
        .desc_err    (desc_err),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    function automatic logic [31:0] mem_word(input logic [18:0] a);
        case (a)
            19'h20004: return 32'h0000_0070;
            19'h20005: return 32'h0002_0001;
            19'h20006: return 32'h0000_0000;
            19'h20007: return 32'h4200_0000;
            default:   return 32'h0000_0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic load_desc(input logic [127:0] w);
        @(negedge clk);
        desc_wr = 1'b1;
        desc_in = w;
        @(negedge clk);
        desc_wr = 1'b0;
    endtask

    task automatic monitor(input int cycles);
        n_op = 0;
        n_rd = 0;
        for (int c = 0; c < cycles; c++) begin
            if (xfer_valid && n_op < 8) begin
                op_log[n_op] = xfer_addr;
                n_op++;
            end
            if (mem_rd_en && n_rd < 8) begin
                rd_log[n_rd] = mem_rd_addr;
                n_rd++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        desc_wr  = 1'b0;
        desc_in  = '0;
        xfer_req = 1'b0;
        mem_rd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 xfer_valid", {31'd0, xfer_valid}, 32'd0);
        chk("R1 mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
        chk("R1 done_irq", {31'd0, done_irq}, 32'd0);
        chk("R1 desc_err", {31'd0, desc_err}, 32'd0);

        // table walk: R2, R3, R4, R10
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            cur = VECS[v];
            tag = (v == 2 || v == 3 || v == 4) ? "R4" : ((v == 5 || v == 6) ? "R2" : "R3");
            load_desc(cur[255:128]);
            n_op = 0; op_sum = 0; op_first = 0; op_last = 0; len_ok = 1'b1;
            for (int c = 0; c < 100 && busy; c++) begin
                if (xfer_valid) begin
                    if (n_op == 0) op_first = xfer_addr;
                    op_last = xfer_addr;
                    op_sum  = op_sum + xfer_addr;
                    n_op++;
                    if (xfer_len !== cur[250:249]) len_ok = 1'b0;
                end
                @(negedge clk);
            end
            chk({tag, " count"}, n_op, cur[127:96]);
            if (cur[127:96] != 0) begin
                chk({tag, " first"}, op_first, cur[95:64]);
                chk({tag, " last"}, op_last, cur[63:32]);
                chk({tag, " sum"}, op_sum, cur[31:0]);
                chk("R10 length tag", {31'd0, len_ok}, 32'd1);
            end
        end

        // R6: interrupt pulse after the last operand
        load_desc({32'h4300_0000, 32'h0, 32'h0002_0001, 32'h0});
        chk("R6 op0", xfer_addr, 32'h0);
        chk("R6 no early irq", {31'd0, done_irq}, 32'd0);
        @(negedge clk);
        chk("R6 op1", {31'd0, xfer_valid}, 32'd1);
        @(negedge clk);
        chk("R6 irq pulse", {31'd0, done_irq}, 32'd1);
        chk("R6 idle", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R6 irq one cycle", {31'd0, done_irq}, 32'd0);

        // R5: request mode
        load_desc({32'h4280_0000, 32'h0, 32'h0003_0001, 32'h10});
        chk("R5 hold no req", {31'd0, xfer_valid}, 32'd0);
        chk("R5 busy waiting", {31'd0, busy}, 32'd1);
        repeat (2) @(negedge clk);
        chk("R5 still holding", {31'd0, xfer_valid}, 32'd0);
        xfer_req = 1'b1;
        #1;
        chk("R5 op on req", {xfer_valid, 31'd0} | xfer_addr, 32'h8000_0010);
        @(negedge clk);
        xfer_req = 1'b0;
        #1;
        chk("R5 gap", {31'd0, xfer_valid}, 32'd0);
        @(negedge clk);
        xfer_req = 1'b1;
        #1;
        chk("R5 second", {xfer_valid, 31'd0} | xfer_addr, 32'h8000_0011);
        @(negedge clk);
        #1;
        chk("R5 third", {xfer_valid, 31'd0} | xfer_addr, 32'h8000_0012);
        @(negedge clk);
        xfer_req = 1'b0;
        #1;
        chk("R5 done", {31'd0, busy}, 32'd0);

        // R7: write to a live descriptor
        load_desc({32'h4400_0000, 32'h0, 32'h0008_0002, 32'h0});
        chk("R7 first op", xfer_addr, 32'h0);
        chk("R7 no error on idle load", {31'd0, desc_err}, 32'd0);
        desc_wr = 1'b1;
        desc_in = {32'h4600_0000, 32'h0, 32'h0010_0004, 32'h500};
        @(negedge clk);
        desc_wr = 1'b0;
        chk("R7 error flag", {31'd0, desc_err}, 32'd1);
        chk("R7 walk kept", xfer_addr, 32'h2);
        @(negedge clk);
        chk("R7 error one cycle", {31'd0, desc_err}, 32'd0);
        chk("R7 walk continues", xfer_addr, 32'h4);
        @(negedge clk);
        chk("R7 last op", xfer_addr, 32'h6);
        @(negedge clk);
        chk("R7 original length", {31'd0, busy}, 32'd0);

        // R8: chained reload
        load_desc({32'h4240_8001, 32'h0, 32'h0001_0001, 32'h30});
        monitor(20);
        chk("R8 read count", n_rd, 32'd4);
        for (int i = 0; i < 4; i++) chk("R8 read addr", {13'd0, rd_log[i]}, 32'h20004 + i);
        chk("R8 op count", n_op, 32'd3);
        chk("R8 op0", op_log[0], 32'h30);
        chk("R8 op1", op_log[1], 32'h70);
        chk("R8 op2", op_log[2], 32'h71);
        chk("R8 idle", {31'd0, busy}, 32'd0);

        // R9: reserved memory block stops the chain
        load_desc({32'h4241_8001, 32'h0, 32'h0001_0001, 32'h5});
        monitor(10);
        chk("R9 op count", n_op, 32'd1);
        chk("R9 no reads", n_rd, 32'd0);
        chk("R9 idle", {31'd0, busy}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule